// File: doc/BRIEF.md
# Fetch Group Aligner with Decoupling Queue

This block sits at the front of an in-order multiple-issue pipeline. Each cycle it shows the instruction cache the current fetch address. The cache returns the whole aligned block holding that address in the same cycle. Instructions are a fixed 4 bytes wide. The block picks out the run of sequential instructions that starts at the fetch address. The run ends at the last slot of the block, or at the first slot at or after the start that the branch predictor marks as predicted-taken. A taken branch is included in the run.

The run is written into a circular queue. The queue decouples fetch from decode, so that cycles in which a short group is fetched do not starve decode. Decode sees the oldest entries at the head and removes up to `DEC_W` of them per cycle. The next fetch address is either the start of the following block or the predicted target.

A misprediction redirect empties the queue and restarts fetch at the corrected address. When the queue cannot take the whole group, fetch stalls and keeps its address. A group is never split.

Top module: `fetch_align_queue`

## Requirements
- R1: After reset, `fetch_pc` equals `RESET_PC` (default 0x100), `q_count` is 0 and `stall` is 0.
- R2: Slot k of a block lies in `blk_data[k*IW +: IW]`, and the starting slot is `fetch_pc[3:2]` (with 4 slots). With no predicted-taken flag at or after the starting slot, every slot from the start to the end of the block is queued, and the next `fetch_pc` is the block base plus 16.
- R3: When `pred_taken[k]` is set for some slot k at or after the starting slot, the group ends at the first such slot, that slot included, and the next `fetch_pc` is `pred_target`. Flags on slots below the starting slot have no effect.
- R4: When `fetch_pc` points at the last slot of a block, exactly one instruction is queued in that cycle.
- R5: The queue is first-in first-out. `head_insn[j*IW +: IW]` is the j-th oldest queued instruction, and `q_count` is the number of queued instructions.
- R6: Each cycle, min(`pop_cnt`, `q_count`) entries leave the head. A push and a pop in the same cycle both take effect.
- R7: `stall` is 1 when the group size exceeds `DEPTH - q_count`. A pop in the same cycle is not counted as freeing room. While stalled, nothing is written and `fetch_pc` holds.
- R8: A `redirect` empties the queue, loads `fetch_pc` from `redirect_pc`, and takes priority over push, pop and stall. In that cycle `stall` reads 0.
- R9: `q_count` never exceeds `DEPTH` (default 18), and the queue can be filled exactly to `DEPTH`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_pc | output | AW | Current fetch address |
| blk_data | input | SLOTS*IW | Aligned block holding `fetch_pc` |
| pred_taken | input | SLOTS | Predicted-taken flag per slot |
| pred_target | input | AW | Predicted target of the taken branch |
| redirect | input | 1 | Misprediction redirect |
| redirect_pc | input | AW | Corrected fetch address |
| pop_cnt | input | $clog2(DEC_W+1) | Entries decode removes this cycle |
| head_insn | output | DEC_W*IW | Oldest DEC_W queue entries |
| q_count | output | $clog2(DEPTH+1) | Queue occupancy |
| stall | output | 1 | Group does not fit; fetch held |

## Verification
The assertions check the following on every cycle:
- occupancy never passes the depth;
- a stall holds the fetch address and never lets occupancy grow;
- a redirect leaves an empty queue and the corrected address;
- a group not cut by a branch leaves the next address block-aligned;
- occupancy never rises in a cycle without a push.

Only the bench scenarios can show the following:
- that the right instructions, in the right order, reach the head;
- the group length for each start slot and flag pattern, including flags below the start being ignored;
- that too large a pop request is clamped;
- that a same-cycle pop does not lift a stall.

// File: rtl/fetch_align_queue.sv
module fetch_align_queue #(
  parameter int AW = 32,
  parameter int IW = 32,
  parameter int SLOTS = 4,
  parameter int DEPTH = 18,
  parameter int DEC_W = 2,
  parameter logic [AW-1:0] RESET_PC = 'h100
) (
  input  logic                         clk,
  input  logic                         rst_n,
  output logic [AW-1:0]                fetch_pc,
  input  logic [SLOTS*IW-1:0]          blk_data,
  input  logic [SLOTS-1:0]             pred_taken,
  input  logic [AW-1:0]                pred_target,
  input  logic                         redirect,
  input  logic [AW-1:0]                redirect_pc,
  input  logic [$clog2(DEC_W+1)-1:0]   pop_cnt,
  output logic [DEC_W*IW-1:0]          head_insn,
  output logic [$clog2(DEPTH+1)-1:0]   q_count,
  output logic                         stall
);
  localparam int OW = $clog2(SLOTS);
  localparam int BW = OW + 2;
  localparam int CW = $clog2(DEPTH+1);
  localparam int PW = $clog2(DEPTH);
  localparam logic [AW-1:0] BLK_BYTES = AW'(SLOTS * 4);

  logic [IW-1:0] mem [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic [OW-1:0] ofs;
  logic [AW-1:0] blk_base;
  logic          hit;
  int            tlane, grp, free_n;
  logic          push;
  logic [CW-1:0] pop_eff, pop_ext;

  function automatic logic [PW-1:0] wrap(input int p);
    return PW'(p >= DEPTH ? p - DEPTH : p);
  endfunction

  assign ofs      = fetch_pc[BW-1:2];
  assign blk_base = {fetch_pc[AW-1:BW], BW'(0)};

  always_comb begin
    hit   = 1'b0;
    tlane = 0;
    for (int k = 0; k < SLOTS; k++)
      if (!hit && k >= int'(ofs) && pred_taken[k]) begin
        hit   = 1'b1;
        tlane = k;
      end
  end

  assign grp     = hit ? tlane - int'(ofs) + 1 : SLOTS - int'(ofs);
  assign free_n  = DEPTH - int'(q_count);
  assign stall   = !redirect && (grp > free_n);
  assign push    = !redirect && !stall;
  assign pop_ext = CW'(pop_cnt);
  assign pop_eff = redirect ? '0 : (pop_ext > q_count ? q_count : pop_ext);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fetch_pc <= RESET_PC;
      rd_ptr   <= '0;
      wr_ptr   <= '0;
      q_count  <= '0;
    end else if (redirect) begin
      fetch_pc <= redirect_pc;
      rd_ptr   <= '0;
      wr_ptr   <= '0;
      q_count  <= '0;
    end else begin
      if (push) begin
        for (int k = 0; k < SLOTS; k++)
          if (k < grp)
            mem[wrap(int'(wr_ptr) + k)] <= blk_data[int'(OW'(int'(ofs) + k))*IW +: IW];
        wr_ptr   <= wrap(int'(wr_ptr) + grp);
        fetch_pc <= hit ? pred_target : blk_base + BLK_BYTES;
      end
      rd_ptr  <= wrap(int'(rd_ptr) + int'(pop_eff));
      q_count <= q_count - pop_eff + (push ? CW'(grp) : CW'(0));
    end
  end

  for (genvar j = 0; j < DEC_W; j++) begin : g_head
    assign head_insn[j*IW +: IW] = mem[wrap(int'(rd_ptr) + j)];
  end

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_count <= CW'(DEPTH));

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (fetch_pc == $past(fetch_pc) && q_count <= $past(q_count)));

  // R8
  redirect_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> (q_count == '0 && fetch_pc == $past(redirect_pc)));

  // R2
  seq_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !hit) |=> fetch_pc[BW-1:0] == '0);

  // R6
  no_push_no_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!redirect && !push) |=> q_count <= $past(q_count));
endmodule

// File: tb/test_fetch_align_queue.sv
`timescale 1ns/1ps
module test_fetch_align_queue;
  logic        clk = 0, rst_n = 0;
  logic [31:0] fetch_pc, pred_target = 0, redirect_pc = 0;
  logic [127:0] blk_data;
  logic [3:0]  pred_taken = 0;
  logic        redirect = 0, stall;
  logic [1:0]  pop_cnt = 0;
  logic [63:0] head_insn;
  logic [4:0]  q_count;
  int checks = 0, errors = 0;

  fetch_align_queue i_fetch_align_queue (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .blk_data(blk_data),
    .pred_taken(pred_taken), .pred_target(pred_target), .redirect(redirect),
    .redirect_pc(redirect_pc), .pop_cnt(pop_cnt), .head_insn(head_insn),
    .q_count(q_count), .stall(stall));

  always #2 clk = ~clk;

  always_comb
    for (int k = 0; k < 4; k++)
      blk_data[k*32 +: 32] = {fetch_pc[31:4], 4'b0} + 32'(4*k);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic go_to(logic [31:0] pc);
    redirect = 1; redirect_pc = pc; pop_cnt = 0; pred_taken = 0;
    cyc();
    redirect = 0;
  endtask

  task automatic t_reset();
    chk("R1 pc", fetch_pc, 32'h100);
    chk("R1 count", 32'(q_count), 0);
    chk("R1 stall", 32'(stall), 0);
  endtask

  task automatic t_seq();
    cyc();
    chk("R2 count", 32'(q_count), 4);
    chk("R2 next pc", fetch_pc, 32'h110);
    chk("R5 head0", head_insn[31:0], 32'h100);
    chk("R5 head1", head_insn[63:32], 32'h104);
    go_to(32'h128);
    chk("R8 pc", fetch_pc, 32'h128);
    chk("R8 count", 32'(q_count), 0);
    cyc();
    chk("R2 mid count", 32'(q_count), 2);
    chk("R2 mid head0", head_insn[31:0], 32'h128);
    chk("R2 mid pc", fetch_pc, 32'h130);
  endtask

  task automatic t_last();
    go_to(32'h13C);
    cyc();
    chk("R4 count", 32'(q_count), 1);
    chk("R4 head0", head_insn[31:0], 32'h13C);
    chk("R4 pc", fetch_pc, 32'h140);
  endtask

  task automatic t_taken();
    go_to(32'h200);
    pred_taken = 4'b0110; pred_target = 32'h300;
    cyc();
    chk("R3 count", 32'(q_count), 2);
    chk("R3 pc", fetch_pc, 32'h300);
    chk("R3 head1", head_insn[63:32], 32'h204);
    go_to(32'h208);
    pred_taken = 4'b1011; pred_target = 32'h380;
    cyc();
    chk("R3 below-start count", 32'(q_count), 2);
    chk("R3 below-start pc", fetch_pc, 32'h380);
    go_to(32'h208);
    pred_taken = 4'b0011;
    cyc();
    chk("R3 ignored flags pc", fetch_pc, 32'h210);
    chk("R3 ignored flags count", 32'(q_count), 2);
    pred_taken = 0;
  endtask

  task automatic t_pop();
    go_to(32'h400);
    cyc();
    chk("R5 count", 32'(q_count), 4);
    pop_cnt = 2;
    cyc();
    chk("R6 push+pop count", 32'(q_count), 6);
    chk("R6 head0", head_insn[31:0], 32'h408);
    chk("R6 head1", head_insn[63:32], 32'h40C);
    go_to(32'h43C);
    cyc();
    chk("R4 single", 32'(q_count), 1);
    pop_cnt = 2;
    cyc();
    chk("R6 clamped pop count", 32'(q_count), 4);
    chk("R6 clamped head0", head_insn[31:0], 32'h440);
    pop_cnt = 0;
  endtask

  task automatic t_stall();
    go_to(32'h500);
    for (int i = 0; i < 4; i++) cyc();
    chk("R7 fill count", 32'(q_count), 16);
    chk("R7 stall raised", 32'(stall), 1);
    cyc();
    chk("R7 pc held", fetch_pc, 32'h540);
    chk("R7 count held", 32'(q_count), 16);
    pop_cnt = 2;
    chk("R7 pop no credit", 32'(stall), 1);
    cyc();
    chk("R7 pc held pop", fetch_pc, 32'h540);
    chk("R7 count after pop", 32'(q_count), 14);
    pop_cnt = 0;
    chk("R7 stall cleared", 32'(stall), 0);
    cyc();
    chk("R9 full count", 32'(q_count), 18);
    chk("R9 pc", fetch_pc, 32'h550);
    chk("R5 head after pops", head_insn[31:0], 32'h508);
    chk("R9 stall when full", 32'(stall), 1);
    redirect = 1; redirect_pc = 32'h600; pop_cnt = 2;
    #0 chk("R8 stall low", 32'(stall), 0);
    cyc();
    redirect = 0; pop_cnt = 0;
    chk("R8 flush count", 32'(q_count), 0);
    chk("R8 flush pc", fetch_pc, 32'h600);
  endtask

  initial begin
    fork
      begin
        repeat (3) cyc();
        rst_n = 1;
        t_reset();
        t_seq();
        t_last();
        t_taken();
        t_pop();
        t_stall();
      end
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule